// File: doc/BRIEF.md
# Serial Packet Framer (Transmit)

This block turns a payload held in a byte FIFO into one framed serial bitstream. A pulse on `start` samples the frame configuration. The block then sends a run of alternating bits as a training pattern, followed by a programmable synchronisation word and the payload bytes pulled from the FIFO. A 16-bit checksum computed over the payload can follow, and its polynomial is chosen from four common ones. A one-cycle `done` pulse marks the end of a complete frame.

Both data paths are valid/ready streams. On the output side one bit moves per cycle in which `out_valid` and `out_ready` are both high. When the downstream sink holds `out_ready` low, the current bit stays on `out_bit` and `out_valid` stays high. On the input side, a byte is taken in the same cycle as the handshake on the last bit of the previous byte, and `in_ready` is raised only in that cycle. Holding back the bit sink therefore holds back the FIFO as well. The FIFO has no way to stall the framer: if `in_valid` is low when a payload byte is needed, the frame is cut short and `err_underflow` pulses.

The control and status pins (`start`, `done`, `err_underflow` and the configuration inputs) are plain levels and pulses.

Top module: `pkt_framer_tx`

## Requirements
- R1: After `start`, the first field sent is `cfg_pre_len` bytes (1 to 255) of alternating bits, and the very first bit is 0.
- R2: The sync field follows the preamble and is `cfg_sync_len`+1 bytes long. It sends byte k of `cfg_sync_word` (bits 8k+7..8k) for k from `cfg_sync_len` down to 0, each byte MSB first.
- R3: Next come `cfg_pay_len` payload bytes taken from the input stream, each sent MSB first. A length of 0 sends no payload.
- R4: When `cfg_crc_en` is 1, 16 checksum bits follow the payload, high byte first. The checksum covers only the payload, MSB-first and unreflected, with a seed of 0xFFFF and no final XOR. `cfg_crc_sel` picks the polynomial: 0 = 0x1021, 1 = 0x8005, 2 = 0x3D65, 3 = 0x8BB7.
- R5: When `cfg_crc_en` is 0, the frame ends directly after the payload with no checksum bits.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` holds its value in the next cycle.
- R7: `in_ready` is high only in a cycle that has an output bit handshake and needs the next payload byte. A byte is consumed when `in_valid` and `in_ready` are both high.
- R8: `done` is high for exactly one cycle, the cycle after the handshake on the final bit of a complete frame, and `out_valid` is low in that cycle.
- R9: A `start` pulse during a frame is ignored. Configuration changes made after a frame has started do not alter that frame.
- R10: If `in_valid` is low when a payload byte is needed, the frame is aborted. In the next cycle `out_valid` is low, `err_underflow` is high for one cycle and `done` stays low.
- R11: While `rst_n` is low and after its release, `out_valid`, `in_ready`, `done` and `err_underflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (ignored when busy) |
| cfg_pre_len | input | 8 | Preamble length in bytes |
| cfg_sync_len | input | 2 | Sync length in bytes minus one |
| cfg_sync_word | input | 32 | Sync pattern, byte k in bits 8k+7..8k |
| cfg_pay_len | input | 8 | Payload length in bytes |
| cfg_crc_en | input | 1 | Append 16-bit checksum |
| cfg_crc_sel | input | 2 | Checksum polynomial select |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Payload byte taken this cycle |
| in_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Sink accepts bit |
| out_bit | output | 1 | Serial output bit |
| done | output | 1 | Frame complete pulse |
| err_underflow | output | 1 | Payload underflow abort pulse |

## Verification
A wrong byte or field counter shows up as a frame of the wrong length: extra or missing preamble or sync bytes, or a `done` pulse at the wrong cycle. The length comparison exposes this at the end of the frame at the latest. A wrong bit counter or a broken shift register corrupts the bits already within the first byte, so the content comparison catches it within eight accepted bits. A broken checksum register appears only in the last 16 bits of the frame. The known-answer frame and frames using all four polynomials pin those bits down. A frame-state machine that ignores a stall or takes a byte at the wrong time violates the hold rule or the ready rule on the very next edge.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SYNC, ST_DATA, ST_CRC, ST_DONE
  } pf_state_e;

  localparam logic [BYTE_W-1:0] PRE_BYTE = 8'h55;

  function automatic logic [CRC_W-1:0] pf_poly(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16'h1021;
      2'd1:    return 16'h8005;
      2'd2:    return 16'h3D65;
      default: return 16'h8BB7;
    endcase
  endfunction
endpackage

// File: rtl/pf_shifter.sv
module pf_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         dout,
  output logic         last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sr_q  <= din;
      cnt_q <= '0;
    end else if (shift) begin
      sr_q  <= {sr_q[W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dout = sr_q[W-1];
  assign last = (cnt_q == CW'(W - 1));

  // R3: a freshly loaded byte always starts at its first bit
  a_r3_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !last);
endmodule

// File: rtl/pf_crc16.sv
module pf_crc16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         en,
  input  logic         bit_i,
  input  logic [W-1:0] poly,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_nx
);
  logic         fb;
  logic [W-1:0] step;

  always_comb begin
    fb     = crc_q[W-1] ^ bit_i;
    step   = {crc_q[W-2:0], 1'b0} ^ (fb ? poly : '0);
    crc_nx = en ? step : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else           crc_q <= crc_nx;
  end

  // R4: checksum only moves on payload bits or a new frame
  a_r4_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !init) |=> $stable(crc_q));
endmodule

// File: rtl/pkt_framer_tx.sv
module pkt_framer_tx
  import pf_pkg::*;
#(
  parameter int PRE_LEN_W  = 8,
  parameter int SYNC_BYTES = 4,
  parameter int PAY_LEN_W  = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [PRE_LEN_W-1:0]               cfg_pre_len,
  input  logic [$clog2(SYNC_BYTES)-1:0]      cfg_sync_len,
  input  logic [SYNC_BYTES*BYTE_W-1:0]       cfg_sync_word,
  input  logic [PAY_LEN_W-1:0]               cfg_pay_len,
  input  logic                               cfg_crc_en,
  input  logic [1:0]                         cfg_crc_sel,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [BYTE_W-1:0]                  in_data,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic                               out_bit,
  output logic                               done,
  output logic                               err_underflow
);
  localparam int SEL_W = $clog2(SYNC_BYTES);
  localparam int CNT_W = (PRE_LEN_W > PAY_LEN_W) ? PRE_LEN_W : PAY_LEN_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pf_state_e state_q, next_state;

  logic [PRE_LEN_W-1:0]         pre_len_q;
  logic [SEL_W-1:0]             sync_n_q;
  logic [SYNC_BYTES*BYTE_W-1:0] sync_q;
  logic [PAY_LEN_W-1:0]         pay_len_q;
  logic                         crc_en_q;
  logic [1:0]                   crc_sel_q;
  logic [CNT_W-1:0]             byte_cnt;
  logic                         err_q;

  logic              load, fetch, underflow, need_data, need_tail;
  logic [BYTE_W-1:0] nbyte;
  logic              sh_bit, sh_last, out_hs, byte_end, kick;
  logic [SEL_W-1:0]  sync_idx;
  logic [CRC_W-1:0]  crc_q, crc_nx;
  logic [CNT_W-1:0]  pre_last, pay_last;

  assign out_valid = (state_q == ST_PRE) || (state_q == ST_SYNC) ||
                     (state_q == ST_DATA) || (state_q == ST_CRC);
  assign out_hs    = out_valid && out_ready;
  assign byte_end  = out_hs && sh_last;
  assign kick      = (state_q == ST_IDLE) && start;
  assign sync_idx  = byte_cnt[SEL_W-1:0] - 1'b1;
  assign pre_last  = CNT_W'(pre_len_q) - ONE;
  assign pay_last  = CNT_W'(pay_len_q) - ONE;

  always_comb begin
    next_state = state_q;
    load       = 1'b0;
    nbyte      = '0;
    fetch      = 1'b0;
    underflow  = 1'b0;
    need_data  = 1'b0;
    need_tail  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        next_state = ST_PRE;
        load       = 1'b1;
        nbyte      = PRE_BYTE;
      end
      ST_PRE: if (byte_end) begin
        load = 1'b1;
        if (byte_cnt == pre_last) begin
          next_state = ST_SYNC;
          nbyte      = sync_q[BYTE_W*sync_n_q +: BYTE_W];
        end else begin
          nbyte = PRE_BYTE;
        end
      end
      ST_SYNC: if (byte_end) begin
        if (byte_cnt == '0) begin
          if (pay_len_q != '0) need_data = 1'b1;
          else                 need_tail = 1'b1;
        end else begin
          load  = 1'b1;
          nbyte = sync_q[BYTE_W*sync_idx +: BYTE_W];
        end
      end
      ST_DATA: if (byte_end) begin
        if (byte_cnt == pay_last) need_tail = 1'b1;
        else                      need_data = 1'b1;
      end
      ST_CRC: if (byte_end) begin
        if (byte_cnt == '0) begin
          load  = 1'b1;
          nbyte = crc_q[BYTE_W-1:0];
        end else begin
          next_state = ST_DONE;
        end
      end
      ST_DONE: next_state = ST_IDLE;
      default: next_state = ST_IDLE;
    endcase

    if (need_data) begin
      fetch = 1'b1;
      if (in_valid) begin
        next_state = ST_DATA;
        load       = 1'b1;
        nbyte      = in_data;
      end else begin
        next_state = ST_IDLE;
        underflow  = 1'b1;
      end
    end
    if (need_tail) begin
      if (crc_en_q) begin
        next_state = ST_CRC;
        load       = 1'b1;
        nbyte      = crc_nx[CRC_W-1 -: BYTE_W];
      end else begin
        next_state = ST_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pre_len_q <= '0;
      sync_n_q  <= '0;
      sync_q    <= '0;
      pay_len_q <= '0;
      crc_en_q  <= 1'b0;
      crc_sel_q <= '0;
      byte_cnt  <= '0;
      err_q     <= 1'b0;
    end else begin
      state_q <= next_state;
      err_q   <= underflow;
      if (kick) begin
        pre_len_q <= cfg_pre_len;
        sync_n_q  <= cfg_sync_len;
        sync_q    <= cfg_sync_word;
        pay_len_q <= cfg_pay_len;
        crc_en_q  <= cfg_crc_en;
        crc_sel_q <= cfg_crc_sel;
      end
      if (next_state != state_q)
        byte_cnt <= (next_state == ST_SYNC) ? CNT_W'(sync_n_q) : '0;
      else if (byte_end)
        byte_cnt <= (state_q == ST_SYNC) ? byte_cnt - ONE : byte_cnt + ONE;
    end
  end

  pf_shifter #(.W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (nbyte),
    .shift (out_hs),
    .dout  (sh_bit),
    .last  (sh_last)
  );

  pf_crc16 #(.W(CRC_W)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (kick),
    .en     ((state_q == ST_DATA) && out_hs),
    .bit_i  (sh_bit),
    .poly   (pf_poly(crc_sel_q)),
    .crc_q  (crc_q),
    .crc_nx (crc_nx)
  );

  assign out_bit       = sh_bit;
  assign in_ready      = fetch;
  assign done          = (state_q == ST_DONE);
  assign err_underflow = err_q;

  // R6: a stalled bit is held
  a_r6_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));
  // R7: a byte is only requested with an output handshake
  a_r7_ready_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_valid && out_ready));
  // R8: completion is a single quiet cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
  // R10: an abort leaves the output idle and never signals completion
  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> (!out_valid && !done));
  // R1: a frame opens with a zero bit
  a_r1_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !out_bit);
  // R9: a start during a frame does not cut the frame short
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start && !byte_end) |=> out_valid);
endmodule

// File: tb/test_pkt_framer_tx.sv
module test_pkt_framer_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cfg_pre_len = 8'd1;
  logic [1:0]  cfg_sync_len = 2'd0;
  logic [31:0] cfg_sync_word = '0;
  logic [7:0]  cfg_pay_len = '0;
  logic        cfg_crc_en = 1'b0;
  logic [1:0]  cfg_crc_sel = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_bit;
  logic        done;
  logic        err_underflow;

  pkt_framer_tx i_pkt_framer_tx (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_pre_len(cfg_pre_len), .cfg_sync_len(cfg_sync_len),
    .cfg_sync_word(cfg_sync_word), .cfg_pay_len(cfg_pay_len),
    .cfg_crc_en(cfg_crc_en), .cfg_crc_sel(cfg_crc_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .done(done), .err_underflow(err_underflow)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit         exp_q[$];
  bit         got_q[$];
  logic [7:0] pay_q[$];
  logic [7:0] fifo_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] poly_of(input logic [1:0] sel);
    case (sel)
      2'd0: return 16'h1021;
      2'd1: return 16'h8005;
      2'd2: return 16'h3D65;
      default: return 16'h8BB7;
    endcase
  endfunction

  function automatic logic [15:0] ref_crc(input logic [1:0] sel);
    logic [15:0] c = 16'hFFFF;
    foreach (pay_q[i])
      for (int b = 7; b >= 0; b--) begin
        bit fb = c[15] ^ pay_q[i][b];
        c = {c[14:0], 1'b0} ^ (fb ? poly_of(sel) : 16'h0);
      end
    return c;
  endfunction

  task automatic frame(input int pre, input int sn, input logic [31:0] sw,
                       input int avail, input bit cen, input logic [1:0] sel,
                       input bit mid_start, input string tag);
    int  plen = pay_q.size();
    bit  under = (avail < plen);
    int  exp_len;
    int  n_done = 0, n_err = 0, hold_bad = 0, rdy_bad = 0, tail_bad = 0;
    int  mism = -1;
    bit  prev_stall = 0, prev_bit = 0, finished = 0;
    logic [15:0] crc;
    exp_q.delete(); got_q.delete(); fifo_q.delete();
    for (int j = 0; j < pre * 8; j++) exp_q.push_back(j % 2 == 1);
    for (int k = sn; k >= 0; k--)
      for (int b = 7; b >= 0; b--) exp_q.push_back(sw[8*k+b]);
    foreach (pay_q[i]) for (int b = 7; b >= 0; b--) exp_q.push_back(pay_q[i][b]);
    crc = ref_crc(sel);
    if (cen) for (int b = 15; b >= 0; b--) exp_q.push_back(crc[b]);
    for (int i = 0; i < avail && i < plen; i++) fifo_q.push_back(pay_q[i]);
    exp_len = under ? (pre + sn + 1 + avail) * 8 : exp_q.size();

    @(negedge clk);
    cfg_pre_len = 8'(pre); cfg_sync_len = 2'(sn); cfg_sync_word = sw;
    cfg_pay_len = 8'(plen); cfg_crc_en = cen; cfg_crc_sel = sel;
    start = 1'b1;
    for (int it = 0; it < 20000 && !finished; it++) begin
      @(negedge clk);
      start = 1'b0;
      if (mid_start && it == 30) begin
        start = 1'b1;
        cfg_pre_len = 8'd3; cfg_sync_len = ~cfg_sync_len;
        cfg_sync_word = ~cfg_sync_word; cfg_pay_len = 8'd1;
        cfg_crc_en = ~cfg_crc_en; cfg_crc_sel = cfg_crc_sel + 2'd1;
      end
      out_ready = ($urandom % 4) != 0;
      in_valid  = fifo_q.size() > 0;
      in_data   = in_valid ? fifo_q[0] : 8'h00;
      #1;
      if (prev_stall && (!out_valid || out_bit != prev_bit)) hold_bad++;
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
      if (in_ready && !(out_valid && out_ready)) rdy_bad++;
      if (out_valid && out_ready) got_q.push_back(out_bit);
      if (in_valid && in_ready) void'(fifo_q.pop_front());
      if (done) begin n_done++; if (out_valid) tail_bad++; finished = 1; end
      if (err_underflow) begin n_err++; if (out_valid || done) tail_bad++; finished = 1; end
    end
    if (!finished) chk(0, "R8", {tag, " watchdog"}, 0, 1);
    foreach (got_q[i]) if (mism < 0 && i < exp_q.size() && got_q[i] != exp_q[i]) mism = i;
    chk(got_q.size() == exp_len, under ? "R10" : (cen ? "R4" : "R5"),
        {tag, " bit count"}, got_q.size(), exp_len);
    chk(mism < 0, "R1 R2 R3", {tag, " first wrong bit index"}, mism, -1);
    chk(n_done == (under ? 0 : 1) && n_err == (under ? 1 : 0),
        under ? "R10" : "R8", {tag, " done/err"}, n_done * 16 + n_err,
        under ? 1 : 16);
    chk(tail_bad == 0, "R8 R10", {tag, " output active at end"}, tail_bad, 0);
    chk(hold_bad == 0, "R6", {tag, " stalled bit changed"}, hold_bad, 0);
    chk(rdy_bad == 0, "R7", {tag, " ready without handshake"}, rdy_bad, 0);
    if (!under) chk(fifo_q.size() == 0, "R7", {tag, " bytes left"}, fifo_q.size(), 0);
    if (mid_start) chk(mism < 0 && got_q.size() == exp_len, "R9",
                       {tag, " start while busy"}, got_q.size(), exp_len);
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(!out_valid && !done, "R8", {tag, " idle after frame"}, out_valid, 0);
    end
  endtask

  task automatic rand_pay(input int n);
    pay_q.delete();
    for (int i = 0; i < n; i++) pay_q.push_back(8'($urandom));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !in_ready && !done && !err_underflow, "R11", "in reset",
        {out_valid, in_ready, done, err_underflow}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid && !in_ready && !done && !err_underflow, "R11", "after reset",
        {out_valid, in_ready, done, err_underflow}, 0);

    // minimal frame: one preamble byte, one sync byte, no payload, no CRC (R5)
    pay_q.delete();
    frame(1, 0, 32'h0000_00D3, 0, 0, 2'd0, 0, "minimal");

    // known answer for R4: payload "123456789", poly 0x1021 -> 0x29B1
    pay_q.delete();
    for (int i = 0; i < 9; i++) pay_q.push_back(8'h31 + 8'(i));
    frame(2, 1, 32'h0000_2DD4, 9, 1, 2'd0, 0, "known");
    begin
      logic [15:0] tail = '0;
      for (int i = 0; i < 16; i++)
        if (got_q.size() >= 16) tail[15-i] = got_q[got_q.size()-16+i];
      chk(tail == 16'h29B1, "R4", "known-answer checksum", tail, 16'h29B1);
    end

    // longest preamble, four sync bytes (R1, R2)
    rand_pay(3);
    frame(255, 3, 32'hA1B2_C3D4, 3, 1, 2'd1, 0, "long preamble");

    // start and config changes mid-frame (R9)
    rand_pay(6);
    frame(4, 2, 32'h0012_3456, 6, 1, 2'd2, 1, "busy start");

    // underflow in the middle and at the first byte (R10)
    rand_pay(5);
    frame(2, 0, 32'h0000_0099, 2, 1, 2'd3, 0, "underflow mid");
    rand_pay(4);
    frame(1, 1, 32'h0000_7E7E, 0, 0, 2'd0, 0, "underflow first");

    // constrained random frames
    for (int n = 0; n < 14; n++) begin
      rand_pay($urandom % 13);
      frame(1 + ($urandom % 24), $urandom % 4, $urandom, pay_q.size(),
            $urandom % 2, 2'($urandom), 0, $sformatf("rand%0d", n));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule